// File: doc/BRIEF.md
# Synchronous Fault Status Capture

This block sits beside a page-table walker and the load/store path of a memory management unit. When the walker or the access checker reports a fault, the block packs what is known about it into a 32-bit status word and keeps the faulting virtual address in a second register. The fault description covers the fault class, the kind of access, the table level reached, and the bus-side error flags. Software reads both words later through a small read port.

A fault that arrives while an earlier fault with a valid address is still unread replaces the earlier record. The block flags that loss in an overwrite bit. A read of the status word returns the current value on the same cycle and empties the register on the following clock edge. Reads of the address word have no side effects.

Top module: `fault_capture`

## Requirements
- R1: When `rst` is high at a clock edge, both the status word and the address word are zero after that edge.
- R2: On a fault event, status bits 4:2 take the fault class code: 0 none, 1 invalid address, 2 protection, 3 privilege violation, 4 translation, 5 access bus error, 6 internal error, 7 reserved.
- R3: On a fault event, status bits 7:5 take the access kind. Bit 5 set means supervisor, bit 6 set means instruction fetch, and bit 7 set means store.
- R4: On a fault event, status bits 9:8 take the table level that faulted: 0 context table, 1 first-level table, 2 second-level table, 3 page table.
- R5: On a fault event, status bit 10 takes the bus-error flag, bit 11 the bus-timeout flag, bit 12 the uncorrectable-error flag, and bit 16 the control-space-error flag. All other status bits not named in R2 to R7 read zero.
- R6: On a fault event, status bit 1 takes `flt_addr_ok`. The address word loads `flt_va`, zero-extended to 32 bits, only on fault events with `flt_addr_ok` high; otherwise it holds its value.
- R7: On a fault event with no status read in the same cycle, status bit 0 is set if bit 1 was already set before the event, and cleared otherwise.
- R8: While `rd_en` is high, `rd_data` shows the status word when `rd_sel` is 0 and the address word when `rd_sel` is 1, in the same cycle. A status read with no fault event in that cycle leaves the status word zero after the edge.
- R9: An address read (`rd_sel` 1) changes neither register.
- R10: When a fault event and a status read fall in the same cycle, the status word takes the new fault with bit 0 clear.
- R11: With no fault event and no status read, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_stb | input | 1 | Fault event strobe, one cycle per fault |
| flt_kind | input | 3 | Fault class code |
| flt_acc | input | 3 | Access kind {store, fetch, supervisor} |
| flt_lvl | input | 2 | Table level reached |
| flt_bus_err | input | 1 | Bus error flag |
| flt_bus_tmo | input | 1 | Bus timeout flag |
| flt_uncorr | input | 1 | Uncorrectable error flag |
| flt_ctl_err | input | 1 | Control-space error flag |
| flt_addr_ok | input | 1 | The faulting address is meaningful |
| flt_va | input | VA_W | Faulting virtual address |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects address |
| rd_data | output | 32 | Read data, combinational |
| stat_word | output | 32 | Current status register |
| addr_word | output | 32 | Current fault address register |

## Verification
The bench builds the block with `VA_W` set to 20. It drives addresses whose upper twelve bits are set, so the zero-extension path of the address register is exercised and seen at the ports. The walk covers all eight fault classes with varied access kinds, levels and error flags. It also covers back-to-back faults with and without a valid address, which exercise both settings of the overwrite bit. Each register's value is compared against the model after every edge, including cycles where a status read and a fault arrive together.

// File: rtl/fltcap_pkg.sv
package fltcap_pkg;

    localparam int STAT_W = 32;

    // status bit positions
    localparam int OW_BIT   = 0;
    localparam int FAV_BIT  = 1;
    localparam int KIND_LSB = 2;
    localparam int ACC_LSB  = 5;
    localparam int LVL_LSB  = 8;
    localparam int BE_BIT   = 10;
    localparam int TMO_BIT  = 11;
    localparam int UC_BIT   = 12;
    localparam int CS_BIT   = 16;

    typedef enum logic [2:0] {
        FK_NONE     = 3'd0,
        FK_BADADDR  = 3'd1,
        FK_PROT     = 3'd2,
        FK_PRIV     = 3'd3,
        FK_XLATE    = 3'd4,
        FK_BUS      = 3'd5,
        FK_INTERNAL = 3'd6,
        FK_RSVD     = 3'd7
    } flt_kind_e;

    typedef enum logic [1:0] {
        LV_CTX  = 2'd0,
        LV_TOP  = 2'd1,
        LV_MID  = 2'd2,
        LV_PAGE = 2'd3
    } walk_lvl_e;

    typedef struct packed {
        logic store;
        logic ifetch;
        logic superv;
    } acc_kind_t;

    typedef struct packed {
        flt_kind_e kind;
        acc_kind_t acc;
        walk_lvl_e lvl;
        logic      bus_err;
        logic      bus_tmo;
        logic      uncorr;
        logic      ctl_err;
        logic      addr_ok;
    } flt_event_t;

    // Build a status word from one event; the overwrite bit comes separately.
    function automatic logic [STAT_W-1:0] pack_status(flt_event_t ev, logic ow);
        logic [STAT_W-1:0] w;
        w = '0;
        w[OW_BIT]                 = ow;
        w[FAV_BIT]                = ev.addr_ok;
        w[KIND_LSB +: 3]          = ev.kind;
        w[ACC_LSB  +: 3]          = ev.acc;
        w[LVL_LSB  +: 2]          = ev.lvl;
        w[BE_BIT]                 = ev.bus_err;
        w[TMO_BIT]                = ev.bus_tmo;
        w[UC_BIT]                 = ev.uncorr;
        w[CS_BIT]                 = ev.ctl_err;
        return w;
    endfunction

endpackage

// File: rtl/fltcap_pack.sv
module fltcap_pack
    import fltcap_pkg::*;
(
    input  flt_event_t        ev,
    input  logic              ow,
    output logic [STAT_W-1:0] word
);
    always_comb begin
        word = pack_status(ev, ow);
    end
endmodule

// File: rtl/fltcap_status.sv
module fltcap_status
    import fltcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_stb,
    input  flt_event_t        ev,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] stat_q
);
    logic              ow_next;
    logic [STAT_W-1:0] packed_word;

    // An unread record with a valid address is lost only if no read
    // consumes it in the same cycle.
    always_comb begin
        ow_next = stat_q[FAV_BIT] & ~rd_clr;
    end

    fltcap_pack u_pack (
        .ev   (ev),
        .ow   (ow_next),
        .word (packed_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (ev_stb) begin
            stat_q <= packed_word;
        end else if (rd_clr) begin
            stat_q <= '0;
        end
    end
endmodule

// File: rtl/fltcap_addr.sv
module fltcap_addr
    import fltcap_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [VA_W-1:0]   va,
    output logic [STAT_W-1:0] addr_q
);
    localparam int PAD_W = STAT_W - VA_W;

    logic [STAT_W-1:0] va_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign va_ext = {{PAD_W{1'b0}}, va};
        end else begin : g_full
            assign va_ext = va[STAT_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= va_ext;
        end
    end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
    import fltcap_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flt_stb,
    input  logic [2:0]      flt_kind,
    input  logic [2:0]      flt_acc,
    input  logic [1:0]      flt_lvl,
    input  logic            flt_bus_err,
    input  logic            flt_bus_tmo,
    input  logic            flt_uncorr,
    input  logic            flt_ctl_err,
    input  logic            flt_addr_ok,
    input  logic [VA_W-1:0] flt_va,
    input  logic            rd_en,
    input  logic            rd_sel,
    output logic [31:0]     rd_data,
    output logic [31:0]     stat_word,
    output logic [31:0]     addr_word
);
    flt_event_t ev;
    logic       rd_stat;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] addr_q;

    always_comb begin
        ev.kind    = flt_kind_e'(flt_kind);
        ev.acc     = acc_kind_t'(flt_acc);
        ev.lvl     = walk_lvl_e'(flt_lvl);
        ev.bus_err = flt_bus_err;
        ev.bus_tmo = flt_bus_tmo;
        ev.uncorr  = flt_uncorr;
        ev.ctl_err = flt_ctl_err;
        ev.addr_ok = flt_addr_ok;
        rd_stat    = rd_en & ~rd_sel;
    end

    fltcap_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .ev_stb (flt_stb),
        .ev     (ev),
        .rd_clr (rd_stat),
        .stat_q (stat_q)
    );

    fltcap_addr #(.VA_W(VA_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load   (flt_stb & flt_addr_ok),
        .va     (flt_va),
        .addr_q (addr_q)
    );

    always_comb begin
        stat_word = stat_q;
        addr_word = addr_q;
        rd_data   = rd_sel ? addr_q : stat_q;
    end
endmodule

// File: rtl/fltcap_chk.sv
module fltcap_chk (
    input logic        clk,
    input logic        rst,
    input logic        flt_stb,
    input logic [2:0]  flt_kind,
    input logic        flt_addr_ok,
    input logic        rd_en,
    input logic        rd_sel,
    input logic [31:0] stat_word,
    input logic [31:0] addr_word
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stat_word == 32'd0 && addr_word == 32'd0));

    // R2
    kind_field_chk: assert property (@(posedge clk) disable iff (rst)
        flt_stb |=> stat_word[4:2] == $past(flt_kind));

    // R7
    overwrite_set_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_stb && stat_word[1] && !(rd_en && !rd_sel)) |=> stat_word[0]);

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_sel && !flt_stb) |=> stat_word == 32'd0);

    // R10
    read_fault_ow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_sel && flt_stb) |=> !stat_word[0]);

    // R11
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flt_stb && !(rd_en && !rd_sel)) |=> $stable(stat_word));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(flt_stb && flt_addr_ok) |=> $stable(addr_word));
endmodule

bind fault_capture fltcap_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .flt_stb     (flt_stb),
    .flt_kind    (flt_kind),
    .flt_addr_ok (flt_addr_ok),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .stat_word   (stat_word),
    .addr_word   (addr_word)
);

// File: tb/sim_fault_capture.sv
`timescale 1ns/1ps
module sim_fault_capture;
    localparam int VA_W = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            flt_stb = 1'b0;
    logic [2:0]      flt_kind = '0;
    logic [2:0]      flt_acc = '0;
    logic [1:0]      flt_lvl = '0;
    logic            flt_bus_err = 1'b0;
    logic            flt_bus_tmo = 1'b0;
    logic            flt_uncorr = 1'b0;
    logic            flt_ctl_err = 1'b0;
    logic            flt_addr_ok = 1'b0;
    logic [VA_W-1:0] flt_va = '0;
    logic            rd_en = 1'b0;
    logic            rd_sel = 1'b0;
    logic [31:0]     rd_data, stat_word, addr_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    longint m_stat = 0;
    longint m_addr = 0;

    always #2.5 clk = ~clk;

    fault_capture #(.VA_W(VA_W)) u0 (
        .clk(clk), .rst(rst), .flt_stb(flt_stb), .flt_kind(flt_kind),
        .flt_acc(flt_acc), .flt_lvl(flt_lvl), .flt_bus_err(flt_bus_err),
        .flt_bus_tmo(flt_bus_tmo), .flt_uncorr(flt_uncorr),
        .flt_ctl_err(flt_ctl_err), .flt_addr_ok(flt_addr_ok), .flt_va(flt_va),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .stat_word(stat_word), .addr_word(addr_word)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check read data, model the
    // rising edge, then check both registers after the next falling edge.
    task automatic step(input bit stb, input int kind, input int acc,
                        input int lvl, input bit be, input bit tmo,
                        input bit uc, input bit cs, input bit aok,
                        input longint va, input bit ren, input bit rsel,
                        input string tag);
        longint nstat, naddr, ow;
        bit     rclr;
        flt_stb = stb; flt_kind = kind[2:0]; flt_acc = acc[2:0];
        flt_lvl = lvl[1:0]; flt_bus_err = be; flt_bus_tmo = tmo;
        flt_uncorr = uc; flt_ctl_err = cs; flt_addr_ok = aok;
        flt_va = va[VA_W-1:0]; rd_en = ren; rd_sel = rsel;
        #1;
        if (ren) check(tag, "rd_data", rd_data, rsel ? m_addr : m_stat);
        rclr  = ren && !rsel;
        nstat = rclr ? 0 : m_stat;
        naddr = m_addr;
        if (stb) begin
            ow = ((m_stat >> 1) & 1) != 0 && !rclr ? 1 : 0;
            nstat = ow | (longint'(aok) << 1) | (longint'(kind) << 2)
                  | (longint'(acc) << 5) | (longint'(lvl) << 8)
                  | (longint'(be) << 10) | (longint'(tmo) << 11)
                  | (longint'(uc) << 12) | (longint'(cs) << 16);
            if (aok) naddr = va & ((longint'(1) << VA_W) - 1);
        end
        @(posedge clk);
        m_stat = nstat;
        m_addr = naddr;
        @(negedge clk);
        check(tag, "stat_word", stat_word, m_stat);
        check(tag, "addr_word", addr_word, m_addr);
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0,0,0,0,0,0,0,0,tag);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears both registers
        check("R1", "stat_word", stat_word, 0);
        check("R1", "addr_word", addr_word, 0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: protection fault, store+supervisor, page level,
        // bus error, upper address bits beyond VA_W dropped
        step(1, 2, 5, 3, 1, 0, 0, 0, 1, 64'hFFFABCDE, 0, 0, "R2");
        // R11: idle holds
        idle("R11");
        idle("R11");
        // R9: address read has no side effect
        step(0,0,0,0,0,0,0,0,0,0, 1, 1, "R9");
        step(0,0,0,0,0,0,0,0,0,0, 1, 1, "R9");
        // R7: second fault while valid set sets overwrite
        step(1, 4, 2, 1, 0, 1, 1, 1, 1, 64'h12345, 0, 0, "R7");
        // R8: status read returns value then clears
        step(0,0,0,0,0,0,0,0,0,0, 1, 0, "R8");
        step(0,0,0,0,0,0,0,0,0,0, 1, 0, "R8");
        // R6: fault without valid address, address held, bit 1 clear
        step(1, 6, 1, 0, 0, 0, 0, 1, 0, 64'h55555, 0, 0, "R6");
        // R7: fault after one with bit 1 clear does not set overwrite
        step(1, 1, 0, 2, 0, 0, 0, 0, 1, 64'h0F0F0, 0, 0, "R7");
        // R10: fault coincident with status read: new record, overwrite 0
        step(1, 3, 7, 3, 1, 1, 0, 0, 1, 64'hFEDCB, 1, 0, "R10");
        step(0,0,0,0,0,0,0,0,0,0, 1, 0, "R8");
        // R2 R3 R4 R5: sweep every fault class with varied fields
        for (int k = 0; k < 8; k++) begin
            step(1, k, (k * 3) % 8, k % 4, k[0], k[1], k[2], ~k[0],
                 k[1], 64'hFFF00000 + 64'(k * 4097), 0, 0, "R2");
            step(1, 7 - k, k, 3 - (k % 4), 0, 1, 0, k[2], 1,
                 64'h80001 * 64'(k + 1), 0, 0, "R3");
            step(0,0,0,0,0,0,0,0,0,0, 1, k[0], "R4");
            step(0,0,0,0,0,0,0,0,0,0, 1, 0, "R5");
        end
        // R1: reset mid-run clears a loaded record
        step(1, 5, 6, 2, 1, 1, 1, 1, 1, 64'h3C3C3, 0, 0, "R5");
        rst = 1'b1;
        @(posedge clk);
        m_stat = 0; m_addr = 0;
        @(negedge clk);
        check("R1", "stat_word", stat_word, 0);
        check("R1", "addr_word", addr_word, 0);
        rst = 1'b0;
        idle("R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule